// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as a plain count of seconds. A programmable prescaler divides a 32.768 kHz reference down to a one-second tick. Each tick advances a 32-bit seconds counter. The block also compares the counter against a 32-bit alarm value. Software reaches all state through a small word-wide register port with four addresses.

Two sticky event flags sit in a status word: one records the seconds tick and one records an alarm match. Each flag has its own enable. Each flag drives its own interrupt line. The flags are cleared by writing ones to them. The enables in the same word are plain read/write bits, so one store can re-arm the enables and acknowledge events together.

The register map by address is:
- 0: divider and trim
- 1: seconds
- 2: alarm
- 3: status

Top module: `secs_rtc`

## Requirements
- R1: After reset, all four registers read zero and both interrupt outputs are low.
- R2: A tick occurs every N+1 reference cycles, where N is a nonzero value in bits 15:0 of address 0. Writing address 0 restarts the prescaler, so the first tick comes N+1 cycles after the write edge.
- R3: When bits 15:0 of address 0 are zero, the prescaler period is 32768 cycles.
- R4: Address 1 reads and writes the seconds counter, which increases by one on every tick. When a write and a tick fall in the same cycle, the written value is kept and no increment is applied.
- R5: Address 2 reads and writes the alarm value. Writing it has no other effect.
- R6: Status bit 0 is the alarm flag. It sets on a tick at which the counter's new value equals the alarm value, but only while the alarm enable (status bit 2) is 1.
- R7: Status bit 1 is the tick flag. It sets on every tick, but only while the tick enable (status bit 3) is 1.
- R8: In a status write, a one in bit 0 or bit 1 clears that flag and a zero leaves it unchanged. Bits 3:2 take the written value in the same write.
- R9: When a flag's set event and a write-one clear of that flag fall in the same cycle, the flag ends up set.
- R10: The alarm interrupt output equals flag bit 0 AND enable bit 2. The tick interrupt output equals flag bit 1 AND enable bit 3. Clearing an enable drops its output while the flag stays set.
- R11: Bits 31:16 of address 0 hold a trim value that reads back as written and does not change the tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_irq | output | 1 | Seconds-tick interrupt |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
Two pairs of events can land on the same edge:
- A software store to the status word can meet a tick that sets the flag being cleared.
- A store to the seconds counter can meet the tick that would increment it.

The bench provokes each collision by restarting the prescaler with a short divider and counting edges, so that the store lands exactly on the tick edge. A second store one edge away serves as the control case. It judges the outcome from the flag and the counter value read back at the ports. The flag must remain set, the counter must hold the stored value, and the control store must clear or take effect normally.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DEF_RELOAD = 16'd32767
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tick_irq,
  output logic        alarm_irq
);
  localparam logic [1:0] A_DIV = 2'd0, A_SEC = 2'd1, A_ALM = 2'd2, A_STS = 2'd3;

  logic [31:0] div_q, sec_q, alm_q;
  logic [DIV_W-1:0] pre_q, reload;
  logic al_pend, hz_pend, al_en, hz_en;
  logic tick, al_hit;
  logic [31:0] sec_inc;

  wire wr_div = bus_we && bus_addr == A_DIV;
  wire wr_sec = bus_we && bus_addr == A_SEC;
  wire wr_alm = bus_we && bus_addr == A_ALM;
  wire wr_sts = bus_we && bus_addr == A_STS;

  assign reload  = (div_q[DIV_W-1:0] == '0) ? DEF_RELOAD : div_q[DIV_W-1:0];
  assign tick    = (pre_q == reload);
  assign sec_inc = sec_q + 32'd1;
  assign al_hit  = tick && !wr_sec && al_en && (sec_inc == alm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (wr_div || tick) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sec_q <= '0;
      alm_q <= '0;
    end else begin
      if (wr_div) div_q <= bus_wdata;
      if (wr_alm) alm_q <= bus_wdata;
      if (wr_sec) sec_q <= bus_wdata;
      else if (tick) sec_q <= sec_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_pend <= 1'b0;
      hz_pend <= 1'b0;
      al_en   <= 1'b0;
      hz_en   <= 1'b0;
    end else begin
      al_pend <= al_hit || (al_pend && !(wr_sts && bus_wdata[0]));
      hz_pend <= (tick && hz_en) || (hz_pend && !(wr_sts && bus_wdata[1]));
      if (wr_sts) {hz_en, al_en} <= bus_wdata[3:2];
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = div_q;
      A_SEC:   bus_rdata = sec_q;
      A_ALM:   bus_rdata = alm_q;
      default: bus_rdata = {28'd0, hz_en, al_en, hz_pend, al_pend};
    endcase
  end

  assign tick_irq  = hz_pend && hz_en;
  assign alarm_irq = al_pend && al_en;

  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_sec) |=> sec_q == $past(sec_q) + 32'd1);
  p_sec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_sec) |=> $stable(sec_q));
  p_hz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz_en && !hz_pend) |=> !hz_pend);
  p_al_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_en && !al_pend) |=> !al_pend);
  p_hz_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_pend && !(wr_sts && bus_wdata[1])) |=> hz_pend);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hz_en) |=> hz_pend);
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_div && pre_q <= reload) |=> pre_q <= reload);
endmodule

// File: tb/sim_secs_rtc.sv
module sim_secs_rtc;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tick_irq, alarm_irq;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  secs_rtc u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq), .alarm_irq(alarm_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1'b1; idle(1);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reg", v, 0); end
    chk("R1 irqs", {30'd0, tick_irq, alarm_irq}, 0);

    // R11 trim stored, period unaffected
    wr(0, 32'hA5C3_0003); rd(0, v); chk("R11 readback", v, 32'hA5C3_0003);
    wr(1, 0); wr(0, 32'hFFFF_0003);
    idle(3); rd(1, v); chk("R11 before", v, 0);
    idle(1); rd(1, v); chk("R11 tick", v, 1);

    // R2 sweep of dividers
    for (int d = 1; d <= 6; d++) begin
      wr(0, 1000); wr(1, 0); wr(0, d);
      for (int n = 1; n <= 3; n++) begin
        idle(d); rd(1, v); chk("R2 early", v, n - 1);
        idle(1); rd(1, v); chk("R2 tick", v, n);
      end
    end

    // R3 default period
    wr(0, 1000); wr(1, 5); wr(0, 0);
    idle(32767); rd(1, v); chk("R3 early", v, 5);
    idle(1); rd(1, v); chk("R3 tick", v, 6);

    // R4 write wins over tick
    wr(0, 3); idle(3); wr(1, 100); rd(1, v); chk("R4 write wins", v, 100);
    idle(3); rd(1, v); chk("R4 next", v, 100);
    idle(1); rd(1, v); chk("R4 inc", v, 101);

    // R5 alarm register
    wr(2, 32'hDEAD_BEEF); rd(2, v); chk("R5 readback", v, 32'hDEAD_BEEF);
    rd(3, v); chk("R5 no side effect", v, 0);

    // R6 alarm disabled: no flag
    wr(0, 1000); wr(1, 10); wr(2, 11); wr(3, 0); wr(0, 1);
    idle(4); rd(3, v); chk("R6 disabled", v, 0);
    // R6 enabled: sets on match tick only
    wr(0, 1000); wr(1, 10); wr(2, 12); wr(3, 32'h4); wr(0, 1);
    idle(2); rd(3, v); chk("R6 no match", v, 32'h4);
    idle(2); rd(3, v); chk("R6 match", v, 32'h5);
    chk("R10 alarm irq", alarm_irq, 1);
    wr(3, 0); rd(3, v); chk("R10 pend kept", v, 32'h1);
    chk("R10 alarm irq off", alarm_irq, 0);
    wr(3, 32'h1); rd(3, v); chk("R8 clear alarm", v, 0);

    // R7 tick flag
    wr(0, 3); idle(4); rd(3, v); chk("R7 disabled", v, 0);
    wr(3, 32'h8); wr(0, 3); idle(3); rd(3, v); chk("R7 before", v, 32'h8);
    idle(1); rd(3, v); chk("R7 set", v, 32'hA);
    chk("R10 tick irq", tick_irq, 1);
    // R8 writing zero leaves flag, enables written together
    wr(3, 32'h8); rd(3, v); chk("R8 zero keeps", v, 32'hA);
    wr(3, 32'h6); rd(3, v); chk("R8 clear and swap en", v, 32'h4);
    chk("R10 tick irq low", tick_irq, 0);

    // R9 collision: clear lands on tick edge
    wr(3, 32'h8); wr(0, 3); idle(3); wr(3, 32'hA);
    rd(3, v); chk("R9 set wins", v, 32'hA);
    wr(3, 32'hA); rd(3, v); chk("R9 control clear", v, 32'h8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule